// File: doc/BRIEF.md
# Multi-width aliased general register file

This block holds eight 32-bit general registers and lets each access choose its width: the whole word, the low halfword, or a single byte. Each access carries a 3-bit register index and a 2-bit width code. For byte accesses the index space is folded onto the first four registers. Indices 0 to 3 pick the low byte of registers 0 to 3. Indices 4 to 7 pick bits 15:8 of those same four registers. This lets an execution unit treat the high and low byte halves of the first four registers as eight independent byte registers.

There are two combinational read ports and one write port that commits on the rising clock edge. A write narrower than a word merges into its register: only the addressed byte or halfword changes, and every other bit keeps its old value. A read returns the selected field right-aligned and zero-extended to 32 bits. Reads see the contents from before any write in the same cycle.

Top module: `aliasrf_top`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero, so every read after reset returns 0.
- R2: Width code 2'b10 (word) writes all 32 bits of the register named by the index, and a word read returns all 32 bits of that register.
- R3: Width code 2'b01 (halfword) reads and writes bits 15:0 of the register named by the index, for all eight indices. A halfword write leaves bits 31:16 unchanged.
- R4: Width code 2'b00 (byte) with index 0 to 3 addresses bits 7:0 of registers 0 to 3, respectively.
- R5: Width code 2'b00 with index 4 to 7 addresses bits 15:8 of registers 0 to 3, respectively (index minus four).
- R6: A byte write changes only the addressed 8 bits. Registers 4 to 7 are never modified by any byte write, and the other byte and bits 31:16 of the target are kept.
- R7: Width code 2'b11 is no access: a write with it changes no register, and a read with it returns 0.
- R8: Every read places the selected field at bit 0 and drives all bits above the field's width to 0.
- R9: Both read ports are combinational and independent, and return the register contents before any write to the same location in the same cycle. The written value becomes visible after the clock edge.
- R10: With the write enable low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_width | input | 2 | Write width code (00 byte, 01 half, 10 word, 11 none) |
| wr_data | input | 32 | Write data, field taken from the low bits |
| ra_idx | input | 3 | Read port A register index |
| ra_width | input | 2 | Read port A width code |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_idx | input | 3 | Read port B register index |
| rb_width | input | 2 | Read port B width code |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
The assertions assume that the write controls and width codes are known (not X) at every rising edge after reset. They also assume that reset is held for at least one edge before the first check. The bench meets this by driving every input to a defined value from time zero and changing inputs only on the falling edge. It also keeps reset asserted for three edges. It then sweeps every index against every width code, including the no-access code, on both read ports after word, halfword, byte and no-access writes. Same-cycle read-versus-write overlap is exercised with the read and write pointing at the same field.

// File: rtl/aliasrf_pkg.sv
package aliasrf_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10,
      ACC_NONE = 2'b11
   } acc_width_e;

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned HALF_BITS = 16;

endpackage

// File: rtl/aliasrf_locate.sv
module aliasrf_locate
   import aliasrf_pkg::*;
#(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned WORD_W   = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]  idx,
   input  acc_width_e        width,
   output logic [IDX_W-1:0]  phys,
   output logic              hi_byte,
   output logic [WORD_W-1:0] field_mask,
   output logic              active
);

   localparam logic [WORD_W-1:0] BYTE_MASK = {{(WORD_W-BYTE_BITS){1'b0}}, {BYTE_BITS{1'b1}}};
   localparam logic [WORD_W-1:0] HALF_MASK = {{(WORD_W-HALF_BITS){1'b0}}, {HALF_BITS{1'b1}}};
   localparam logic [WORD_W-1:0] WORD_MASK = {WORD_W{1'b1}};

   always_comb begin
      phys       = idx;
      hi_byte    = 1'b0;
      field_mask = '0;
      active     = 1'b0;
      unique case (width)
         ACC_BYTE: begin
            // upper index half folds onto the high byte of the lower registers
            phys       = {1'b0, idx[IDX_W-2:0]};
            hi_byte    = idx[IDX_W-1];
            field_mask = BYTE_MASK;
            active     = 1'b1;
         end
         ACC_HALF: begin
            field_mask = HALF_MASK;
            active     = 1'b1;
         end
         ACC_WORD: begin
            field_mask = WORD_MASK;
            active     = 1'b1;
         end
         default: begin
            active     = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/aliasrf_rdport.sv
module aliasrf_rdport
   import aliasrf_pkg::*;
#(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned WORD_W   = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
   input  logic [IDX_W-1:0]                idx,
   input  acc_width_e                      width,
   output logic [WORD_W-1:0]               data
);

   logic [IDX_W-1:0]  phys;
   logic              hi_byte;
   logic [WORD_W-1:0] field_mask;
   logic              active;
   logic [WORD_W-1:0] aligned;

   aliasrf_locate #(
      .NUM_REGS (NUM_REGS),
      .WORD_W   (WORD_W)
   ) i_locate (
      .idx        (idx),
      .width      (width),
      .phys       (phys),
      .hi_byte    (hi_byte),
      .field_mask (field_mask),
      .active     (active)
   );

   always_comb begin
      aligned = hi_byte ? (regs[phys] >> BYTE_BITS) : regs[phys];
      data    = active ? (aligned & field_mask) : '0;
   end

   always_comb begin
      if (!$isunknown({width, data})) begin
         AST_NONE_READ_ZERO: assert (width != ACC_NONE || data == '0); // R7
         AST_BYTE_READ_ZEXT: assert (width != ACC_BYTE || data[WORD_W-1:BYTE_BITS] == '0); // R8
      end
   end

endmodule

// File: rtl/aliasrf_store.sv
module aliasrf_store
   import aliasrf_pkg::*;
#(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned WORD_W   = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            we,
   input  logic [IDX_W-1:0]                phys,
   input  logic                            hi_byte,
   input  logic [WORD_W-1:0]               field_mask,
   input  logic [WORD_W-1:0]               wdata,
   output logic [NUM_REGS-1:0][WORD_W-1:0] regs
);

   logic [WORD_W-1:0] lane_mask;
   logic [WORD_W-1:0] lane_data;

   always_comb begin
      if (hi_byte) begin
         lane_mask = field_mask << BYTE_BITS;
         lane_data = (wdata & field_mask) << BYTE_BITS;
      end else begin
         lane_mask = field_mask;
         lane_data = wdata & field_mask;
      end
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            regs[r] <= '0;
         end else if (we && phys == IDX_W'(r)) begin
            regs[r] <= (regs[r] & ~lane_mask) | lane_data;
         end
      end
   end

endmodule

// File: rtl/aliasrf_top.sv
module aliasrf_top
   import aliasrf_pkg::*;
#(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned WORD_W   = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS),
   localparam int unsigned ALIASED = NUM_REGS / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_width,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [1:0]        ra_width,
   output logic [WORD_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [1:0]        rb_width,
   output logic [WORD_W-1:0] rb_data
);

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_count
      $fatal(1, "aliasrf_top: NUM_REGS must be a power of two, at least 2");
   end
   if (WORD_W < HALF_BITS) begin : g_bad_width
      $fatal(1, "aliasrf_top: WORD_W must hold at least a halfword");
   end

   logic [NUM_REGS-1:0][WORD_W-1:0] regs;
   logic [IDX_W-1:0]  w_phys;
   logic              w_hi;
   logic [WORD_W-1:0] w_mask;
   logic              w_active;

   aliasrf_locate #(
      .NUM_REGS (NUM_REGS),
      .WORD_W   (WORD_W)
   ) i_wlocate (
      .idx        (wr_idx),
      .width      (acc_width_e'(wr_width)),
      .phys       (w_phys),
      .hi_byte    (w_hi),
      .field_mask (w_mask),
      .active     (w_active)
   );

   aliasrf_store #(
      .NUM_REGS (NUM_REGS),
      .WORD_W   (WORD_W)
   ) i_store (
      .clk        (clk),
      .rst        (rst),
      .we         (wr_en && w_active),
      .phys       (w_phys),
      .hi_byte    (w_hi),
      .field_mask (w_mask),
      .wdata      (wr_data),
      .regs       (regs)
   );

   aliasrf_rdport #(
      .NUM_REGS (NUM_REGS),
      .WORD_W   (WORD_W)
   ) i_rd_a (
      .regs  (regs),
      .idx   (ra_idx),
      .width (acc_width_e'(ra_width)),
      .data  (ra_data)
   );

   aliasrf_rdport #(
      .NUM_REGS (NUM_REGS),
      .WORD_W   (WORD_W)
   ) i_rd_b (
      .regs  (regs),
      .idx   (rb_idx),
      .width (acc_width_e'(rb_width)),
      .data  (rb_data)
   );

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> regs == '0); // R1
   AST_NONE_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_width == ACC_NONE) |=> $stable(regs)); // R7
   AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(regs)); // R10
   AST_BYTE_SPARES_UPPER_REGS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_width == ACC_BYTE) |=> $stable(regs[NUM_REGS-1:ALIASED])); // R6

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
      AST_WORD_LANDS: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_width == ACC_WORD && wr_idx == IDX_W'(r))
         |=> regs[r] == $past(wr_data)); // R2
      if (WORD_W > HALF_BITS) begin : g_upper
         AST_HALF_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_width == ACC_HALF && wr_idx == IDX_W'(r))
            |=> $stable(regs[r][WORD_W-1:HALF_BITS])); // R3
      end
   end

endmodule

// File: tb/test_aliasrf_top.sv
`timescale 1ns/1ps
module test_aliasrf_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [1:0]  wr_width = 2'b11;
   logic [31:0] wr_data = '0;
   logic [2:0]  ra_idx = '0;
   logic [1:0]  ra_width = 2'b10;
   logic [31:0] ra_data;
   logic [2:0]  rb_idx = '0;
   logic [1:0]  rb_width = 2'b10;
   logic [31:0] rb_data;

   int total = 0;
   int bad   = 0;
   logic [31:0] model [8];

   always #2.5 clk = ~clk;

   aliasrf_top i_aliasrf_top (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_width(wr_width), .wr_data(wr_data),
      .ra_idx(ra_idx), .ra_width(ra_width), .ra_data(ra_data),
      .rb_idx(rb_idx), .rb_width(rb_width), .rb_data(rb_data)
   );

   function automatic logic [31:0] expect_read(input int idx, input int w);
      case (w)
         0: return (idx < 4) ? (model[idx] % 256) : ((model[idx-4] / 256) % 256);
         1: return model[idx] % 65536;
         2: return model[idx];
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_write(input int idx, input int w, input logic [31:0] d);
      case (w)
         0: if (idx < 4) model[idx] = model[idx] - (model[idx] % 256) + (d % 256);
            else model[idx-4] = model[idx-4] - (((model[idx-4] / 256) % 256) * 256)
                                 + ((d % 256) * 256);
         1: model[idx] = model[idx] - (model[idx] % 65536) + (d % 65536);
         2: model[idx] = d;
         default: ;
      endcase
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_for(input int idx, input int w);
      case (w)
         0: return (idx < 4) ? "R4 R8 byte-low" : "R5 R8 byte-high";
         1: return "R3 R8 half";
         2: return "R2 word";
         default: return "R7 none-read";
      endcase
   endfunction

   // sweep every index and width on both ports against the model
   task automatic sweep_reads();
      for (int i = 0; i < 8; i++) begin
         for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            ra_idx = 3'(i); ra_width = 2'(w);
            rb_idx = 3'(7 - i); rb_width = 2'(3 - w);
            #1;
            check(tag_for(i, w), ra_data, expect_read(i, w));
            check({tag_for(7 - i, 3 - w), " R9 portB"}, rb_data, expect_read(7 - i, 3 - w));
         end
      end
   endtask

   task automatic do_write(input int idx, input int w, input logic [31:0] d, input logic en);
      @(negedge clk);
      wr_en = en; wr_idx = 3'(idx); wr_width = 2'(w); wr_data = d;
      @(posedge clk);
      if (en) model_write(idx, w, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset contents
      for (int i = 0; i < 8; i++) begin
         ra_idx = 3'(i); ra_width = 2'b10; #1;
         check("R1 reset", ra_data, 32'd0);
         @(negedge clk);
      end
      // word fill with distinct patterns
      for (int i = 0; i < 8; i++) do_write(i, 2, 32'hA5000000 + i * 32'h01030507 + 32'h1111, 1'b1);
      sweep_reads();
      // R4 R5 R6: byte writes over all eight byte indices
      for (int i = 0; i < 8; i++) do_write(i, 0, 32'hFFFF_FF00 + 32'(i * 17 + 3), 1'b1);
      sweep_reads();
      for (int i = 4; i < 8; i++) begin
         @(negedge clk); ra_idx = 3'(i); ra_width = 2'b10; #1;
         check("R6 byte write spares upper regs", ra_data, model[i]);
      end
      // R3: halfword writes keep the top
      for (int i = 0; i < 8; i++) do_write(i, 1, 32'h7777_0000 + 32'(i * 4099), 1'b1);
      sweep_reads();
      // R7: no-access writes, R10: disabled writes
      for (int i = 0; i < 8; i++) do_write(i, 3, 32'hDEAD_BEEF, 1'b1);
      for (int i = 0; i < 8; i++) do_write(i, 2, 32'hCAFE_F00D, 1'b0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); ra_idx = 3'(i); ra_width = 2'b10; #1;
         check("R7 R10 ignored write", ra_data, model[i]);
      end
      // R9: same-cycle read sees old value, new value after edge
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd5; wr_width = 2'b00; wr_data = 32'h0000_003C;
      ra_idx = 3'd5; ra_width = 2'b00; rb_idx = 3'd1; rb_width = 2'b10; #1;
      check("R9 read before write A", ra_data, expect_read(5, 0));
      check("R9 read before write B", rb_data, model[1]);
      @(posedge clk); model_write(5, 0, 32'h3C);
      @(negedge clk); wr_en = 1'b0; #1;
      check("R9 after edge A", ra_data, 32'h3C);
      check("R9 after edge B", rb_data, model[1]);
      // pseudo-random mixed traffic
      begin
         logic [31:0] lf = 32'h1ACE_B00C;
         for (int n = 0; n < 300; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_write(int'(lf[2:0]), int'(lf[4:3]), lf, lf[5] | lf[6]);
            ra_idx = lf[9:7]; ra_width = lf[11:10];
            rb_idx = lf[14:12]; rb_width = lf[16:15]; #1;
            check({tag_for(int'(lf[9:7]), int'(lf[11:10])), " mixed"}, ra_data,
                  expect_read(int'(lf[9:7]), int'(lf[11:10])));
            check({tag_for(int'(lf[14:12]), int'(lf[16:15])), " mixed B"}, rb_data,
                  expect_read(int'(lf[14:12]), int'(lf[16:15])));
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule